// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. Pages are 4 KB: the low twelve address bits are the byte offset within the page and are copied straight into the result, and the upper twenty bits form the virtual page number. The page number, scaled to a word index, is added to a table base register to give the address of the entry. The block then issues a single word read on a request/acknowledge memory port and inspects the returned entry.

An entry whose valid flag is set supplies the physical page number, which is placed above the untouched offset. An entry with a clear valid flag makes the block report a page fault instead of an address. The base register can only be loaded while the supervisor-mode input is high. A translation is accepted only when the walker is idle, and each translation finishes with a single-cycle completion strobe.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req`, `done`, `fault` and `paddr` are all 0.
- R2: The cycle after a request is accepted, `mem_req` is 1 and `mem_addr` equals the base register plus four times `req_vaddr[31:12]`, modulo 2^32. Both stay unchanged until the cycle in which `mem_ack` is seen.
- R3: Each translation makes exactly one read, and `mem_req` is 0 in the cycle after the acknowledge.
- R4: When bit 31 of `mem_rdata` is 1 at the acknowledge, the result has `fault` = 0 and `paddr` = {`mem_rdata[19:0]`, `req_vaddr[11:0]`}.
- R5: When bit 31 of `mem_rdata` is 0 at the acknowledge, the result has `fault` = 1 and `paddr` = 0.
- R6: `done` is 1 for exactly one cycle per translation, in the cycle after the acknowledge. `fault` and `paddr` are 0 whenever `done` is 0.
- R7: A request is taken only while `req_ready` is 1. `req_ready` is 0 from acceptance until after the `done` cycle, and requests raised in that window start no read.
- R8: A write on `base_wr_en` loads `base_wr_data` into the base register only when `sup_mode` is 1. A write with `sup_mode` at 0 leaves the base unchanged.
- R9: Entry bit 30 (dirty) and bits 29:20 (reserved) have no effect on `fault` or `paddr`.
- R10: If a base write coincides with the acceptance of a request, that request uses the base value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| sup_mode | input | 1 | Supervisor mode; enables base register writes |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_data | input | 32 | New table base value |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Entry byte address |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 32 | Returned page table entry |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 32 | Physical address, valid with done and no fault |

## Verification
The bench builds the walker with its default parameters: a 32-bit virtual address, 4 KB pages, a 20-bit physical page number, 4-byte entries and a 32-bit physical address. These sizes allow it to reach the highest page number, the point where the scaled page number added to the base wraps past 2^32, and entries with every reserved and dirty bit set. Memory latencies of zero and several cycles cover both the immediate acknowledge and a request that is held while stray requests arrive.

// File: rtl/pgwalk_pkg.sv
// Shared types for the page table walker.
// Assumes: nothing beyond IEEE 1800-2017.
package pgwalk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } walk_state_e;
endpackage

// File: rtl/pgwalk_base_reg.sv
// Page table base register.
// Loads a new value only when the write strobe and supervisor mode are both high.
// Assumes: wr_data is sampled on the same edge as wr_en.
module pgwalk_base_reg #(
    parameter int          AW      = 32,
    parameter logic [31:0] RST_VAL = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          sup_mode,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_q
);
    // Hold the base; accept privileged writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= RST_VAL[AW-1:0];
        else if (wr_en && sup_mode)
            base_q <= wr_data;
    end
endmodule

// File: rtl/pgwalk_addr_gen.sv
// Entry address generator: base + page number * entry size, modulo 2^AW.
// Assumes: ENTRY_BYTES is a power of two and AW >= VPN_W.
module pgwalk_addr_gen #(
    parameter int AW          = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [AW-1:0]    base,
    input  logic [VPN_W-1:0] vpn,
    output logic [AW-1:0]    entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [AW-1:0] vpn_ext;

    generate
        if (AW > VPN_W) begin : g_pad
            assign vpn_ext = {{(AW-VPN_W){1'b0}}, vpn};
        end else begin : g_flat
            assign vpn_ext = vpn;
        end
    endgenerate

    // Scale the page number to a byte offset and add the base.
    always_comb begin
        entry_addr = base + (vpn_ext << SHIFT);
    end
endmodule

// File: rtl/pgwalk_pte_decode.sv
// Entry decoder: extracts the valid flag and builds the physical address
// from the physical page number and the page offset.
// Assumes: valid flag at VALID_BIT, page number in the low PPN_W bits;
// all other entry bits carry no meaning here.
module pgwalk_pte_decode #(
    parameter int ENTRY_W   = 32,
    parameter int VALID_BIT = 31,
    parameter int PPN_W     = 20,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 32
) (
    input  logic [ENTRY_W-1:0] pte,
    input  logic [OFF_W-1:0]   offset,
    output logic               hit,
    output logic [PA_W-1:0]    pa
);
    localparam int PA_NAT = PPN_W + OFF_W;

    logic [PA_NAT-1:0] pa_nat;
    logic              unused_pte_bits;

    // Status and reserved bits are deliberately ignored.
    assign unused_pte_bits = ^pte;

    // Valid flag and natural-width address.
    always_comb begin
        hit    = pte[VALID_BIT];
        pa_nat = {pte[PPN_W-1:0], offset};
    end

    generate
        if (PA_W > PA_NAT) begin : g_pa_pad
            assign pa = {{(PA_W-PA_NAT){1'b0}}, pa_nat};
        end else begin : g_pa_exact
            assign pa = pa_nat[PA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer: IDLE -> READ (one outstanding read) -> DONE (one cycle).
// Latches the entry address and page offset on acceptance, and the result on acknowledge.
// Assumes: mem_ack is only meaningful while mem_req is high.
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_off,
    input  logic [AW-1:0]    entry_addr,
    input  logic             mem_ack,
    input  logic             pte_hit,
    input  logic [PA_W-1:0]  pte_pa,
    output logic             idle,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [OFF_W-1:0] off_q,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  paddr
);
    walk_state_e   state_q;
    logic [AW-1:0] addr_q;
    logic          fault_q;
    logic [PA_W-1:0] pa_q;

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) state_q <= ST_READ;
                ST_READ: if (mem_ack)   state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture entry address and offset at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q <= entry_addr;
            off_q  <= req_off;
        end
    end

    // Capture the translation result at acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else if (state_q == ST_READ && mem_ack) begin
            fault_q <= !pte_hit;
            pa_q    <= pte_hit ? pte_pa : '0;
        end
    end

    // Drive outputs from state; results are gated by the strobe.
    always_comb begin
        idle     = (state_q == ST_IDLE);
        mem_req  = (state_q == ST_READ);
        mem_addr = addr_q;
        done     = (state_q == ST_DONE);
        fault    = done && fault_q;
        paddr    = (done && !fault_q) ? pa_q : '0;
    end
endmodule

// File: rtl/pgwalk_top.sv
// Page table walker top: base register, entry address generator,
// entry decoder and walk sequencer.
// Assumes: single-level table, one entry word per page, memory answers every request.
module pgwalk_top #(
    parameter int          VA_W        = 32,
    parameter int          OFF_W       = 12,
    parameter int          PPN_W       = 20,
    parameter int          ENTRY_BYTES = 4,
    parameter int          VALID_BIT   = 31,
    parameter int          PA_W        = 32,
    parameter logic [31:0] BASE_RST    = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            req_ready,
    input  logic            sup_mode,
    input  logic            base_wr_en,
    input  logic [31:0]     base_wr_data,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            done,
    output logic            fault,
    output logic [PA_W-1:0] paddr
);
    localparam int AW      = 32;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int ENTRY_W = ENTRY_BYTES * 8;

    logic [AW-1:0]    base_q;
    logic [AW-1:0]    entry_addr;
    logic [OFF_W-1:0] off_q;
    logic             pte_hit;
    logic [PA_W-1:0]  pte_pa;

    pgwalk_base_reg #(.AW(AW), .RST_VAL(BASE_RST)) base_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_wr_en),
        .sup_mode (sup_mode),
        .wr_data  (base_wr_data),
        .base_q   (base_q)
    );

    pgwalk_addr_gen #(.AW(AW), .VPN_W(VPN_W), .ENTRY_BYTES(ENTRY_BYTES)) addr_i (
        .base       (base_q),
        .vpn        (req_vaddr[VA_W-1:OFF_W]),
        .entry_addr (entry_addr)
    );

    pgwalk_pte_decode #(
        .ENTRY_W(ENTRY_W), .VALID_BIT(VALID_BIT), .PPN_W(PPN_W),
        .OFF_W(OFF_W), .PA_W(PA_W)
    ) dec_i (
        .pte    (mem_rdata[ENTRY_W-1:0]),
        .offset (off_q),
        .hit    (pte_hit),
        .pa     (pte_pa)
    );

    pgwalk_ctrl #(.AW(AW), .OFF_W(OFF_W), .PA_W(PA_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_off    (req_vaddr[OFF_W-1:0]),
        .entry_addr (entry_addr),
        .mem_ack    (mem_ack),
        .pte_hit    (pte_hit),
        .pte_pa     (pte_pa),
        .idle       (req_ready),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .off_q      (off_q),
        .done       (done),
        .fault      (fault),
        .paddr      (paddr)
    );
endmodule

// File: rtl/pgwalk_checker.sv
// Protocol and result checker for the page table walker, bound to the top.
module pgwalk_checker #(
    parameter int OFF_W     = 12,
    parameter int PPN_W     = 20,
    parameter int VALID_BIT = 31,
    parameter int PA_W      = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req,
    input logic [31:0]     mem_addr,
    input logic            mem_ack,
    input logic [31:0]     mem_rdata,
    input logic            done,
    input logic            fault,
    input logic [PA_W-1:0] paddr
);
    // R1: reset leaves no read and no result pending.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !done && req_ready));

    // R2: a pending read holds its address until acknowledged.
    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: the request drops after the acknowledge.
    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R6: completion strobe lasts one cycle and follows an acknowledge.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_ack));

    // R5: a clear valid flag yields a fault.
    p_fault_on_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_rdata[VALID_BIT]) |=> (done && fault && paddr == '0));

    // R4: a set valid flag yields the entry's page number.
    p_hit_ppn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_rdata[VALID_BIT]) |=>
            (done && !fault && paddr[OFF_W +: PPN_W] == $past(mem_rdata[PPN_W-1:0])));

    // R7: no new request is taken while a walk is in flight.
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));
endmodule

bind pgwalk_top pgwalk_checker #(
    .OFF_W(OFF_W), .PPN_W(PPN_W), .VALID_BIT(VALID_BIT), .PA_W(PA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (done),
    .fault     (fault),
    .paddr     (paddr)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_ready;
    logic        sup_mode;
    logic        base_wr_en;
    logic [31:0] base_wr_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        done;
    logic        fault;
    logic [31:0] paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model_base = 32'h0;

    always #2 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .sup_mode(sup_mode), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry(input logic [31:0] base, input logic [31:0] va);
        return base + {va[31:12], 2'b00};
    endfunction

    // Base write at a negedge; model follows R8.
    task automatic write_base(input bit sup, input logic [31:0] val);
        @(negedge clk);
        sup_mode = sup; base_wr_en = 1'b1; base_wr_data = val;
        @(negedge clk);
        base_wr_en = 1'b0; sup_mode = 1'b0;
        if (sup) model_base = val;
    endtask

    // One translation; poke drives stray requests while busy.
    task automatic walk(input logic [31:0] va, input logic [31:0] pte, input int lat,
                        input bit poke, input string tag);
        logic [31:0] ea;
        bit          exp_fault;
        logic [31:0] exp_pa;
        ea        = exp_entry(model_base, va);
        exp_fault = !pte[31];
        exp_pa    = pte[31] ? {pte[19:0], va[11:0]} : 32'h0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", {tag, " ready before request"}, {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req == 1'b1, "R2", {tag, " mem_req after accept"}, {31'h0, mem_req}, 32'h1);
        chk(mem_addr == ea, "R2", {tag, " entry address"}, mem_addr, ea);
        for (int i = 0; i < lat; i++) begin
            if (poke) begin
                req_valid = 1'b1; req_vaddr = ~va;
                chk(req_ready == 1'b0, "R7", {tag, " ready low while busy"}, {31'h0, req_ready}, 32'h0);
            end
            @(negedge clk);
            chk(mem_req == 1'b1 && mem_addr == ea, "R2", {tag, " address held"}, mem_addr, ea);
        end
        mem_ack = 1'b1; mem_rdata = pte;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'h0;
        chk(done == 1'b1, "R6", {tag, " done after ack"}, {31'h0, done}, 32'h1);
        chk(mem_req == 1'b0, "R3", {tag, " request dropped"}, {31'h0, mem_req}, 32'h0);
        chk(fault == exp_fault, exp_fault ? "R5" : "R4", {tag, " fault"}, {31'h0, fault}, {31'h0, exp_fault});
        chk(paddr == exp_pa, exp_fault ? "R5" : "R4", {tag, " paddr"}, paddr, exp_pa);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0 && fault == 1'b0 && paddr == 32'h0, "R6", {tag, " strobe one cycle"},
            {30'h0, done, fault}, 32'h0);
        chk(mem_req == 1'b0, "R7", {tag, " no extra read"}, {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready", {31'h0, req_ready}, 32'h1);
        chk(mem_req == 1'b0, "R1", "mem_req", {31'h0, mem_req}, 32'h0);
        chk(done == 1'b0 && fault == 1'b0, "R1", "done/fault", {30'h0, done, fault}, 32'h0);
        chk(paddr == 32'h0, "R1", "paddr", paddr, 32'h0);
    endtask

    task automatic t_hit();
        write_base(1'b1, 32'h0010_0000);
        walk(32'h1234_5ABC, 32'h8000_0ABC, 0, 1'b0, "R4 hit lat0");
        walk(32'hFFFF_F001, 32'h8001_2345, 3, 1'b0, "R4 top page lat3");
    endtask

    task automatic t_fault();
        walk(32'h0000_3FFF, 32'h7FFF_FFFF, 1, 1'b0, "R5 invalid");
    endtask

    task automatic t_status_bits();
        walk(32'hABCD_E777, 32'hFFFF_F123, 2, 1'b0, "R9 dirty+reserved");
        walk(32'hABCD_E777, 32'h8000_F123, 0, 1'b0, "R9 clean");
    endtask

    task automatic t_user_write();
        write_base(1'b0, 32'hDEAD_0000);
        walk(32'h0000_1000, 32'h8000_0001, 0, 1'b0, "R8 user write ignored");
        write_base(1'b1, 32'h0200_0000);
        walk(32'h0000_1000, 32'h8000_0001, 0, 1'b0, "R8 supervisor write");
    endtask

    task automatic t_busy();
        walk(32'h5555_5123, 32'h8000_0042, 4, 1'b1, "R7 busy requests");
    endtask

    task automatic t_wrap();
        write_base(1'b1, 32'hFFFF_FFF0);
        walk(32'h0000_5000, 32'h8000_0007, 0, 1'b0, "R2 wrap");
        chk(exp_entry(model_base, 32'h0000_5000) == 32'h0000_0004, "R2", "wrap model",
            exp_entry(model_base, 32'h0000_5000), 32'h0000_0004);
    endtask

    task automatic t_same_cycle();
        logic [31:0] old_base;
        old_base = model_base;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_2000;
        sup_mode = 1'b1; base_wr_en = 1'b1; base_wr_data = 32'h0800_0000;
        @(negedge clk);
        req_valid = 1'b0; base_wr_en = 1'b0; sup_mode = 1'b0;
        model_base = 32'h0800_0000;
        chk(mem_addr == exp_entry(old_base, 32'h0000_2000), "R10", "old base used",
            mem_addr, exp_entry(old_base, 32'h0000_2000));
        mem_ack = 1'b1; mem_rdata = 32'h8000_0003;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(done == 1'b1 && paddr == 32'h0000_3000, "R10", "result", paddr, 32'h0000_3000);
        walk(32'h0000_2000, 32'h8000_0003, 0, 1'b0, "R10 new base next");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; sup_mode = 1'b0;
        base_wr_en = 1'b0; base_wr_data = '0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_fault();
        t_status_bits();
        t_user_write();
        t_busy();
        t_wrap();
        t_same_cycle();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule